// File: doc/BRIEF.md
# Scratchpad Command Engine

This block is the byte-level command processor of a small single-wire EEPROM slave. A bit-timing front end hands it whole received bytes and asks it for bytes to send. The block holds the target address (a low byte and a high byte), a status byte and an eight-byte scratchpad, and it runs three commands. Read Scratchpad (AAh) sends the address and status bytes, the selected scratchpad bytes and an inverted CRC-16. Copy Scratchpad (55h) checks a three-byte echo of the address and status registers and then writes the scratchpad into memory. Read Memory (F0h) streams memory bytes starting at an address the master supplies.

A neighbouring block loads the scratchpad through a one-cycle load port. Memory sits outside, behind a synchronous read port with one cycle of latency and a write port eight bytes wide. A timer of configurable length models the copy. While the timer runs, `busy` blocks every other input.

States and transitions:
- `S_CMD` waits for a command byte. AAh goes to `S_RS_TX`, 55h to `S_CP_AUTH`, F0h to `S_RM_ADDR`, and any other byte to `S_DEAD`.
- `S_RS_TX` sends bytes in order through the phases HDR0, HDR1, HDR2, DATA, CRCL, CRCH and END.
- `S_CP_AUTH` takes three bytes. It goes to `S_CP_BUSY` if the copy is accepted and to `S_DEAD` if it is refused.
- `S_CP_BUSY` goes to `S_CP_DONE` when the timer expires.
- `S_RM_ADDR` goes to `S_RM_DATA` after it has taken two address bytes.
- `S_DEAD` and `S_CP_DONE` hold until a bus reset.
- A bus reset sends every state except `S_CP_BUSY` back to `S_CMD`.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After reset `busy`, `rd_valid` and `mem_we` are low. A read request in the command state returns FFh.
- R2: Every read request gives `rd_valid` high for exactly the next cycle, with the byte on `rd_byte`. Read Scratchpad (AAh) sends the bytes in this order: address low byte, address high byte, status byte, then scratchpad bytes from offset address[2:0] up to the ending offset. The status byte is laid out as bit7 = accepted flag, bit5 = partial flag, bits2:0 = ending offset. Scratchpad byte k is `ld_data[8k+7:8k]`.
- R3: After the data, Read Scratchpad sends the inverted CRC-16, low byte first. The CRC uses polynomial x^16+x^15+x^2+1, a zero seed and LSB-first input, and covers every byte sent before it. All later reads return FFh.
- R4: Copy Scratchpad (55h) followed by the address low byte, address high byte and status byte, each matching exactly, is accepted when the address is at most 008Fh, the partial flag is clear and the target page is unprotected. On acceptance the flag in status bit7 is set and `busy` is high for COPY_CYCLES cycles. `mem_we` pulses once, in the last busy cycle, with `mem_wrow` = address[7:3] and `mem_wdata` = scratchpad (byte k to address row*8+k).
- R5: If any echoed byte differs, there is no write, bit7 stays clear and reads return FFh until a bus reset.
- R6: If the partial flag is set, or the `page_prot` bit of the target page (address[7:5]) is set, the copy is refused exactly as in R5.
- R7: A target address above 008Fh refuses the copy exactly as in R5.
- R8: During the copy, reads return FFh. After it, every read returns AAh until a bus reset.
- R9: Read Memory (F0h) takes the address low byte, then the high byte, and then returns memory from that address upward. Addresses above 008Fh return FFh.
- R10: Read Memory leaves the address, status and scratchpad registers unchanged.
- R11: A bus reset outside a copy aborts the command in progress. The next byte is decoded as a command.
- R12: While `busy` is high, received bytes, loads and bus resets are ignored.
- R13: An unknown command byte makes every read return FFh and every received byte ignored until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset seen by the front end |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to send |
| rd_valid | output | 1 | Byte to send is valid |
| rd_byte | output | 8 | Byte to send |
| ld_valid | input | 1 | Scratchpad load strobe |
| ld_ta | input | 16 | Target address to load |
| ld_end | input | 3 | Ending offset to load |
| ld_pf | input | 1 | Partial flag to load |
| ld_data | input | 64 | Scratchpad bytes to load |
| page_prot | input | NPAGE | Copy protection, one bit per page |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | MAW | Memory read address |
| mem_rd_data | input | 8 | Memory read data, one cycle after enable |
| mem_we | output | 1 | Memory row write strobe |
| mem_wrow | output | MAW-3 | Memory row written |
| mem_wdata | output | 64 | Row data |
| busy | output | 1 | Copy in progress |

## Verification
The window while the copy timer runs is the hardest to reach. It needs a load, a command and three echo bytes that all match, and then stimulus placed inside a window of fixed length. The bench computes the echo from its own register model and sends it. It then steps through every busy cycle, checking `busy` and `mem_we` in each. Inside the same window it injects a command byte, a load, a bus reset and a read. After the copy, the AAh pattern, the unchanged scratchpad and a Read Memory over the written row show that the injected inputs had no effect.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam logic [7:0] CMD_RD_SPAD = 8'hAA;
    localparam logic [7:0] CMD_COPY    = 8'h55;
    localparam logic [7:0] CMD_RD_MEM  = 8'hF0;

    typedef enum logic [2:0] {
        S_CMD,
        S_RS_TX,
        S_CP_AUTH,
        S_CP_BUSY,
        S_CP_DONE,
        S_RM_ADDR,
        S_RM_DATA,
        S_DEAD
    } scm_state_e;

    typedef enum logic [2:0] {
        PH_HDR0,
        PH_HDR1,
        PH_HDR2,
        PH_DATA,
        PH_CRCL,
        PH_CRCH,
        PH_END
    } scm_phase_e;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/scm_crc16.sv
module scm_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import scm_pkg::*;

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '0;
        else if (clr) crc_q <= '0;
        else if (en)  crc_q <= crc16_step(crc_q, din);
    end

    assign crc = crc_q;

    // R3: the register only moves when a byte is fed or it is cleared
    a_r3_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc_q));

endmodule

// File: rtl/scm_copy_timer.sv
module scm_copy_timer #(
    parameter int COPY_CYCLES = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(COPY_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(COPY_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // R4: busy cannot end before the count has run out
    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);

    // R12: a new copy is never started while one runs
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/scm_auth.sv
module scm_auth (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    input  logic [7:0] exp0,
    input  logic [7:0] exp1,
    input  logic [7:0] exp2,
    output logic       last,
    output logic       match
);
    logic [1:0] idx_q;
    logic       bad_q;
    logic [7:0] exp_b;

    always_comb begin
        unique case (idx_q)
            2'd0:    exp_b = exp0;
            2'd1:    exp_b = exp1;
            default: exp_b = exp2;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            bad_q <= 1'b0;
        end else if (clr) begin
            idx_q <= '0;
            bad_q <= 1'b0;
        end else if (en && idx_q != 2'd2) begin
            idx_q <= idx_q + 1'b1;
            bad_q <= bad_q | (din != exp_b);
        end
    end

    assign last  = en && (idx_q == 2'd2);
    assign match = !bad_q && (din == exp2);

    // R5: the echo index never runs past the third byte
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q != 2'd3);

endmodule

// File: rtl/scratch_cmd_engine.sv
module scratch_cmd_engine #(
    parameter int          COPY_CYCLES = 48,
    parameter logic [15:0] MEM_LAST    = 16'h008F,
    parameter int          PAGE_SHIFT  = 5,
    parameter int          NPAGE       = (int'(MEM_LAST) + (1 << PAGE_SHIFT)) >> PAGE_SHIFT,
    parameter int          MAW         = $clog2(int'(MEM_LAST) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    input  logic             ld_valid,
    input  logic [15:0]      ld_ta,
    input  logic [2:0]       ld_end,
    input  logic             ld_pf,
    input  logic [63:0]      ld_data,
    input  logic [NPAGE-1:0] page_prot,
    output logic             mem_rd_en,
    output logic [MAW-1:0]   mem_rd_addr,
    input  logic [7:0]       mem_rd_data,
    output logic             mem_we,
    output logic [MAW-4:0]   mem_wrow,
    output logic [63:0]      mem_wdata,
    output logic             busy
);
    import scm_pkg::*;

    scm_state_e  state_q, state_d;
    scm_phase_e  phase_q, phase_d;
    logic [2:0]  pos_q, pos_d;
    logic [7:0]  ta1_q, ta2_q, es_q;
    logic [63:0] sp_q;
    logic [15:0] rm_ptr_q;
    logic        rm_hi_q;
    logic        rd_valid_q, rd_mem_q;
    logic [7:0]  rd_q;

    logic [15:0] ta_w;
    logic        tmr_busy, tmr_done;
    logic        auth_last, auth_match, accept;
    logic        addr_ok, prot_hit;
    logic        live, cmd_ok, auth_en, auth_clr, rs_go;
    logic [7:0]  rsp_byte;
    logic        rsp_mem;
    logic        crc_en;
    logic [7:0]  crc_din;
    logic [15:0] crc_w;
    logic        rm_in_range;

    assign ta_w        = {ta2_q, ta1_q};
    assign live        = !(bus_rst && !tmr_busy);
    assign cmd_ok      = live && rx_valid && (state_q == S_CMD);
    assign rs_go       = cmd_ok && (rx_byte == CMD_RD_SPAD);
    assign auth_clr    = cmd_ok && (rx_byte == CMD_COPY);
    assign auth_en     = live && rx_valid && (state_q == S_CP_AUTH);
    assign addr_ok     = (ta_w <= MEM_LAST);
    assign rm_in_range = (rm_ptr_q <= MEM_LAST);

    always_comb begin
        prot_hit = 1'b0;
        for (int p = 0; p < NPAGE; p++) begin
            if ((int'(ta_w) >> PAGE_SHIFT) == p) prot_hit = page_prot[p];
        end
    end

    assign accept = auth_last && auth_match && addr_ok && !es_q[5] && !prot_hit;

    scm_auth u_auth (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (auth_clr),
        .en    (auth_en),
        .din   (rx_byte),
        .exp0  (ta1_q),
        .exp1  (ta2_q),
        .exp2  (es_q),
        .last  (auth_last),
        .match (auth_match)
    );

    scm_copy_timer #(.COPY_CYCLES(COPY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    scm_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rs_go),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_w)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!live) begin
            state_d = S_CMD;
        end else begin
            unique case (state_q)
                S_CMD: begin
                    if (rx_valid) begin
                        if (rx_byte == CMD_RD_SPAD)     state_d = S_RS_TX;
                        else if (rx_byte == CMD_COPY)   state_d = S_CP_AUTH;
                        else if (rx_byte == CMD_RD_MEM) state_d = S_RM_ADDR;
                        else                            state_d = S_DEAD;
                    end
                end
                S_CP_AUTH: if (auth_last) state_d = accept ? S_CP_BUSY : S_DEAD;
                S_CP_BUSY: if (tmr_done) state_d = S_CP_DONE;
                S_RM_ADDR: if (rx_valid && rm_hi_q) state_d = S_RM_DATA;
                S_RS_TX, S_CP_DONE, S_RM_DATA, S_DEAD: state_d = state_q;
                default: state_d = S_CMD;
            endcase
        end
    end

    // byte selection for a read request
    always_comb begin
        rsp_byte  = 8'hFF;
        rsp_mem   = 1'b0;
        mem_rd_en = 1'b0;
        crc_en    = 1'b0;
        crc_din   = 8'h00;
        phase_d   = phase_q;
        pos_d     = pos_q;
        if (rd_req) begin
            unique case (state_q)
                S_RS_TX: begin
                    unique case (phase_q)
                        PH_HDR0: begin rsp_byte = ta1_q; crc_en = 1'b1; phase_d = PH_HDR1; end
                        PH_HDR1: begin rsp_byte = ta2_q; crc_en = 1'b1; phase_d = PH_HDR2; end
                        PH_HDR2: begin rsp_byte = es_q;  crc_en = 1'b1; phase_d = PH_DATA; end
                        PH_DATA: begin
                            rsp_byte = sp_q[{pos_q, 3'b000} +: 8];
                            crc_en   = 1'b1;
                            if (pos_q == es_q[2:0]) phase_d = PH_CRCL;
                            else                    pos_d   = pos_q + 1'b1;
                        end
                        PH_CRCL: begin rsp_byte = ~crc_w[7:0];  phase_d = PH_CRCH; end
                        PH_CRCH: begin rsp_byte = ~crc_w[15:8]; phase_d = PH_END;  end
                        default: rsp_byte = 8'hFF;
                    endcase
                    crc_din = rsp_byte;
                end
                S_CP_DONE: rsp_byte = 8'hAA;
                S_RM_DATA: begin
                    if (rm_in_range) begin
                        rsp_mem   = 1'b1;
                        mem_rd_en = 1'b1;
                    end
                end
                S_CMD, S_CP_AUTH, S_CP_BUSY, S_RM_ADDR, S_DEAD: rsp_byte = 8'hFF;
                default: rsp_byte = 8'hFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CMD;
        else        state_q <= state_d;
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta1_q      <= '0;
            ta2_q      <= '0;
            es_q       <= '0;
            sp_q       <= '0;
            phase_q    <= PH_HDR0;
            pos_q      <= '0;
            rm_ptr_q   <= '0;
            rm_hi_q    <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_mem_q   <= 1'b0;
            rd_q       <= 8'hFF;
        end else begin
            rd_valid_q <= rd_req;
            rd_mem_q   <= rsp_mem;
            rd_q       <= rsp_byte;
            phase_q    <= phase_d;
            pos_q      <= pos_d;
            if (accept) begin
                es_q[7] <= 1'b1;
            end else if (ld_valid && !tmr_busy) begin
                ta1_q <= ld_ta[7:0];
                ta2_q <= ld_ta[15:8];
                es_q  <= {1'b0, 1'b0, ld_pf, 2'b00, ld_end};
                sp_q  <= ld_data;
            end
            if (rs_go) begin
                phase_q <= PH_HDR0;
                pos_q   <= ta1_q[2:0];
            end
            if (cmd_ok && rx_byte == CMD_RD_MEM) rm_hi_q <= 1'b0;
            if (live && rx_valid && state_q == S_RM_ADDR) begin
                if (!rm_hi_q) begin
                    rm_ptr_q[7:0] <= rx_byte;
                    rm_hi_q       <= 1'b1;
                end else begin
                    rm_ptr_q[15:8] <= rx_byte;
                end
            end
            if (rd_req && state_q == S_RM_DATA && rm_in_range) rm_ptr_q <= rm_ptr_q + 1'b1;
        end
    end

    assign rd_valid    = rd_valid_q;
    assign rd_byte     = rd_mem_q ? mem_rd_data : rd_q;
    assign mem_rd_addr = rm_ptr_q[MAW-1:0];
    assign mem_we      = tmr_done;
    assign mem_wrow    = ta_w[MAW-1:3];
    assign mem_wdata   = sp_q;
    assign busy        = tmr_busy;

    // R2: a valid byte always answers a request of the previous cycle
    a_r2_rd_answer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R4: a row write only happens inside an accepted copy
    a_r4_we_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state_q == S_CP_BUSY));

    // R4: the accepted flag only rises out of the echo check
    a_r4_aa_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(es_q[7]) |-> ($past(state_q) == S_CP_AUTH));

    // R10: read memory leaves the held registers untouched
    a_r10_rm_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RM_ADDR || state_q == S_RM_DATA) && !ld_valid)
        |=> $stable({ta1_q, ta2_q, es_q, sp_q}));

    // R12: the scratchpad is frozen while the copy runs
    a_r12_sp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |=> $stable(sp_q));

    // R8: after the copy every answer is the alternating pattern
    a_r8_done_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CP_DONE && rd_req && !bus_rst) |=> (rd_byte == 8'hAA));

endmodule

// File: tb/test_scratch_cmd_engine.sv
module test_scratch_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int C_CYC      = 48;
    localparam int LASTA      = 143;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_ta = '0;
    logic [2:0]  ld_end = '0;
    logic        ld_pf = 1'b0;
    logic [63:0] ld_data = '0;
    logic [4:0]  page_prot = '0;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        mem_we;
    logic [4:0]  mem_wrow;
    logic [63:0] mem_wdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit we_ok  = 1'b0;
    bit ended  = 1'b0;

    logic [7:0] bmem [0:LASTA];
    logic [7:0] refm [0:LASTA];

    // bench register model
    logic [15:0] m_ta;
    logic [2:0]  m_end;
    logic        m_pf;
    logic        m_aa;
    logic [7:0]  m_sp [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_cmd_engine i_scratch_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .ld_valid(ld_valid), .ld_ta(ld_ta), .ld_end(ld_end), .ld_pf(ld_pf), .ld_data(ld_data),
        .page_prot(page_prot),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_we(mem_we), .mem_wrow(mem_wrow), .mem_wdata(mem_wdata),
        .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_rd_en && int'(mem_rd_addr) <= LASTA) mem_rd_data <= bmem[mem_rd_addr];
        if (mem_we) begin
            for (int k = 0; k < 8; k++) bmem[{mem_wrow, 3'b000} + k] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_we && !we_ok) check("R5 stray mem_we", 1, 0);
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_es();
        return {m_aa, 1'b0, m_pf, 2'b00, m_end};
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b, input string tag);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check({tag, " rd_valid"}, int'(rd_valid), 1);
        b = rd_byte;
    endtask

    task automatic breset();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic load(input logic [15:0] ta, input logic [2:0] e, input logic pf, input logic [7:0] base);
        @(negedge clk);
        ld_valid = 1'b1; ld_ta = ta; ld_end = e; ld_pf = pf;
        for (int k = 0; k < 8; k++) begin
            ld_data[8*k +: 8] = base + 8'(k * 17);
            m_sp[k] = base + 8'(k * 17);
        end
        m_ta = ta; m_end = e; m_pf = pf; m_aa = 1'b0;
        @(negedge clk); ld_valid = 1'b0;
    endtask

    task automatic rs_check(input string tag);
        logic [7:0]  q[$];
        logic [15:0] c = 16'h0000;
        logic [7:0]  b;
        breset();
        send(8'hAA);
        q.push_back(m_ta[7:0]); q.push_back(m_ta[15:8]); q.push_back(m_es());
        for (int k = int'(m_ta[2:0]); k <= int'(m_end); k++) q.push_back(m_sp[k]);
        foreach (q[i]) c = crc_upd(c, q[i]);
        q.push_back(~c[7:0]); q.push_back(~c[15:8]);
        q.push_back(8'hFF); q.push_back(8'hFF);
        foreach (q[i]) begin
            rd(b, tag);
            check($sformatf("%s byte %0d", tag, i), int'(b), int'(q[i]));
        end
    endtask

    task automatic copy_refused(input string tag);
        logic [7:0] b;
        breset();
        send(8'h55); send(m_ta[7:0]); send(m_ta[15:8]); send(m_es());
        check({tag, " busy"}, int'(busy), 0);
        rd(b, tag);
        check({tag, " reads FF"}, int'(b), 8'hFF);
        rs_check({tag, " AA clear"});
    endtask

    task automatic rm_check(input logic [15:0] a, input int n, input string tag);
        logic [7:0] b;
        breset();
        send(8'hF0); send(a[7:0]); send(a[15:8]);
        for (int i = 0; i < n; i++) begin
            int ad = int'(a) + i;
            rd(b, tag);
            check($sformatf("%s addr %0h", tag, ad), int'(b), ad <= LASTA ? int'(refm[ad]) : 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            check("watchdog", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        for (int i = 0; i <= LASTA; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        m_ta = '0; m_end = '0; m_pf = 1'b0; m_aa = 1'b0;
        for (int k = 0; k < 8; k++) m_sp[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 mem_we", int'(mem_we), 0);
        rd(b, "R1");
        check("R1 idle read", int'(b), 8'hFF);
        @(negedge clk);
        check("R2 rd_valid one cycle", int'(rd_valid), 0);

        // R2 R3 partial and full scratchpad reads
        load(16'h0013, 3'd6, 1'b0, 8'h10);
        rs_check("R2 R3 partial");
        load(16'h0040, 3'd7, 1'b0, 8'h05);
        rs_check("R2 R3 full");

        // R5 mismatching echo
        load(16'h0048, 3'd7, 1'b0, 8'h21);
        breset();
        send(8'h55); send(m_ta[7:0]); send(8'h01); send(m_es());
        rd(b, "R5");
        check("R5 mismatch reads FF", int'(b), 8'hFF);
        rs_check("R5 AA clear");

        // R6 partial flag and page protection
        load(16'h0048, 3'd7, 1'b1, 8'h21);
        copy_refused("R6 pf");
        load(16'h0020, 3'd7, 1'b0, 8'h33);
        page_prot = 5'b00010;
        copy_refused("R6 prot");
        page_prot = 5'b00000;

        // R7 out of range target
        load(16'h0090, 3'd7, 1'b0, 8'h44);
        copy_refused("R7 0090");
        load(16'h0108, 3'd7, 1'b0, 8'h44);
        copy_refused("R7 0108");

        // R4 R8 R12 accepted copy
        load(16'h0048, 3'd7, 1'b0, 8'h62);
        breset();
        send(8'h55); send(m_ta[7:0]); send(m_ta[15:8]); send(m_es());
        we_ok = 1'b1;
        for (int i = 0; i < C_CYC; i++) begin
            check($sformatf("R4 busy cyc %0d", i), int'(busy), 1);
            check($sformatf("R4 mem_we cyc %0d", i), int'(mem_we), i == C_CYC - 1 ? 1 : 0);
            if (i == C_CYC - 1) begin
                check("R4 row", int'(mem_wrow), 9);
                for (int k = 0; k < 8; k++) check("R4 wdata", int'(mem_wdata[8*k +: 8]), int'(m_sp[k]));
            end
            if (i == 9) begin
                check("R12 rd_valid busy", int'(rd_valid), 1);
                check("R8 busy reads FF", int'(rd_byte), 8'hFF);
            end
            rx_valid = (i == 2); rx_byte = 8'hF0;
            ld_valid = (i == 4); ld_data = '1; ld_ta = 16'h0000;
            bus_rst  = (i == 6);
            rd_req   = (i == 8);
            @(negedge clk);
        end
        we_ok = 1'b0;
        check("R4 busy end", int'(busy), 0);
        for (int k = 0; k < 8; k++) refm[72 + k] = m_sp[k];
        m_aa = 1'b1;
        rd(b, "R8"); check("R8 pattern 1", int'(b), 8'hAA);
        rd(b, "R8"); check("R8 pattern 2", int'(b), 8'hAA);
        rs_check("R4 R12 after copy");

        // R9 read memory across the copied row and past the end
        rm_check(16'h0046, 12, "R9 R4 row");
        rm_check(16'h008D, 5, "R9 end");
        rm_check(16'h0200, 2, "R9 high");
        // R10 registers unchanged
        rs_check("R10 after rm");

        // R11 aborts
        breset();
        send(8'hAA);
        rd(b, "R11"); rd(b, "R11");
        rm_check(16'h0010, 2, "R11 abort rs");
        breset();
        send(8'h55); send(m_ta[7:0]);
        rs_check("R11 abort copy");

        // R13 unknown command
        breset();
        send(8'h33);
        rd(b, "R13"); check("R13 reads FF", int'(b), 8'hFF);
        send(8'hAA);
        rd(b, "R13"); check("R13 byte ignored", int'(b), 8'hFF);
        rs_check("R13 recover");

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule